// File: doc/BRIEF.md
# Loopback Mode Controller

This block steers the serial transmit and receive paths of a network controller according to a two-bit loopback selection held in the transmit configuration register. The same register holds a CRC enable bit. The block decodes the selection into one-hot path-select lines. It then routes serializer output, receive data and receive clock in one of four ways:

- normal operation;
- internal loopback, where the transmit side feeds the deserializer directly;
- loopback inside the external encoder/decoder;
- loopback through the attached medium.

The block refuses a direct jump between two loopback settings; the selection must return to normal first. A refused write is ignored, and a sticky flag records it.

On the receive side the block gates the checks that run on the returned frame. An address-match result is reported for every frame. A CRC verdict is produced in normal mode, and in loopback only when the CRC enable bit is set. Both results appear as one-cycle pulses after the end-of-frame strobe rises. A loopback run starts with an ordinary transmit command once the mode is programmed, and an in-flight flag tracks it.

Top module: `loopback_ctrl`

## Requirements
- R1: After reset the mode is 00 (normal), CRC enable is 0, the illegal flag is 0, the in-flight flag is 0 and all status pulses are 0.
- R2: path_sel_o is one-hot with bit index equal to the mode value: bit0 normal (00), bit1 internal (01), bit2 encoder/decoder (10), bit3 medium (11). mode_o shows the mode value.
- R3: A configuration write takes effect on the clock edge where it is sampled when it is legal. A write is legal when the new mode is 00, the current mode is 00, or the new mode equals the current mode. Both mode and CRC enable are updated. With cfg_we_i low, the configuration is unchanged.
- R4: A write requesting a direct change between two different non-zero modes is ignored entirely: mode and CRC enable are kept. lb_illegal_o goes to 1 and stays 1 through other writes until a write of mode 00, which clears it.
- R5: In internal mode (01), deser_rxd_o equals ser_txd_i and deser_clk_o equals tx_clk_i. endec_txd_o is held at 0 and medium_tx_en_o at 0.
- R6: In encoder/decoder mode (10), endec_txd_o equals ser_txd_i and endec_loop_o is 1. medium_tx_en_o is 0. deser_rxd_o/deser_clk_o come from endec_rxd_i/endec_rx_clk_i.
- R7: In normal (00) and medium (11) modes, endec_txd_o equals ser_txd_i and medium_tx_en_o equals tx_en_i. endec_loop_o is 0, and receive data and clock come from the encoder/decoder inputs.
- R8: tx_crc_gen_o equals the stored CRC enable bit.
- R9: One cycle after rx_eof_i rises, addr_match_o pulses high for exactly one cycle if rx_addr_hit_i was high. This holds even if rx_eof_i stays high.
- R10: At that same point, crc_pass_o (when rx_crc_ok_i is 1) or crc_fail_o (when it is 0) pulses for one cycle if the mode is 00 or CRC enable is 1. Neither pulses in a loopback mode with CRC enable 0.
- R11: lb_active_o rises one cycle after tx_start_i is sampled in a non-zero mode. It falls one cycle after rx_eof_i rises, or when the mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Requested loopback mode |
| cfg_crc_en_i | input | 1 | Requested CRC enable |
| tx_start_i | input | 1 | Transmit command |
| tx_en_i | input | 1 | Transmit enable from serializer |
| ser_txd_i | input | SER_W | Serializer output data |
| tx_clk_i | input | 1 | Transmit clock |
| endec_rxd_i | input | SER_W | Receive data from encoder/decoder |
| endec_rx_clk_i | input | 1 | Receive clock from encoder/decoder |
| rx_eof_i | input | 1 | Receive end-of-frame strobe |
| rx_addr_hit_i | input | 1 | Destination address matched |
| rx_crc_ok_i | input | 1 | Received CRC correct |
| mode_o | output | 2 | Current mode |
| path_sel_o | output | 4 | One-hot path select |
| lb_illegal_o | output | 1 | Sticky refused-change flag |
| tx_crc_gen_o | output | 1 | Transmit CRC generation enable |
| lb_active_o | output | 1 | Loopback frame in flight |
| endec_txd_o | output | SER_W | Data to encoder/decoder |
| medium_tx_en_o | output | 1 | Drive enable toward medium |
| endec_loop_o | output | 1 | Request loop inside encoder/decoder |
| deser_rxd_o | output | SER_W | Deserializer input data |
| deser_clk_o | output | 1 | Deserializer clock |
| addr_match_o | output | 1 | Address-match pulse |
| crc_pass_o | output | 1 | CRC pass pulse |
| crc_fail_o | output | 1 | CRC fail pulse |

## Verification
A corrupted stored mode appears at once on path_sel_o and mode_o. It also changes the data and clock routing combinationally in the same cycle, so the fault is visible without waiting for a frame. A wrong legality decision appears one edge after the write, as a mode that moved when it should not have (or stayed when it should have moved), together with a mismatched illegal flag. A wrong CRC gating or edge-detect state appears one cycle after the end-of-frame strobe rises, as a missing, extra or repeated status pulse.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int NUM_MODES = 4;
  localparam int MODE_W    = $clog2(NUM_MODES);

  typedef enum logic [MODE_W-1:0] {
    LB_NORMAL   = 2'b00,
    LB_INTERNAL = 2'b01,
    LB_ENDEC    = 2'b10,
    LB_MEDIUM   = 2'b11
  } lb_mode_e;
endpackage

// File: rtl/lb_mode_reg.sv
module lb_mode_reg
  import lb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  input  logic              wr_crc_en_i,
  output lb_mode_e          mode_o,
  output logic              crc_en_o,
  output logic              illegal_o
);
  lb_mode_e mode_q;
  logic     crc_q;
  logic     ill_q;
  logic     legal;

  // only transitions touching normal, or rewriting the same mode, are allowed
  always_comb begin
    legal = (wr_mode_i == LB_NORMAL) || (mode_q == LB_NORMAL) ||
            (wr_mode_i == mode_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= LB_NORMAL;
      crc_q  <= 1'b0;
      ill_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (legal) begin
        mode_q <= lb_mode_e'(wr_mode_i);
        crc_q  <= wr_crc_en_i;
      end
      if (!legal)                       ill_q <= 1'b1;
      else if (wr_mode_i == LB_NORMAL)  ill_q <= 1'b0;
    end
  end

  assign mode_o    = mode_q;
  assign crc_en_o  = crc_q;
  assign illegal_o = ill_q;

  assert_mode_via_normal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> ($past(mode_q) == LB_NORMAL || mode_q == LB_NORMAL));

  assert_no_write_no_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mode_q) && $stable(crc_q) && $stable(ill_q)));

  assert_refused_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_q != LB_NORMAL && wr_mode_i != LB_NORMAL && wr_mode_i != mode_q)
      |=> ($stable(mode_q) && $stable(crc_q) && ill_q));
endmodule

// File: rtl/lb_path_mux.sv
module lb_path_mux
  import lb_pkg::*;
#(
  parameter int SER_W = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  lb_mode_e             mode_i,
  input  logic                 tx_en_i,
  input  logic [SER_W-1:0]     ser_txd_i,
  input  logic                 tx_clk_i,
  input  logic [SER_W-1:0]     endec_rxd_i,
  input  logic                 endec_rx_clk_i,
  output logic [NUM_MODES-1:0] path_sel_o,
  output logic [SER_W-1:0]     endec_txd_o,
  output logic                 medium_tx_en_o,
  output logic                 endec_loop_o,
  output logic [SER_W-1:0]     deser_rxd_o,
  output logic                 deser_clk_o
);
  logic [NUM_MODES-1:0] sel;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_dec
    assign sel[g] = (mode_i == MODE_W'(g));
  end

  logic internal_lb;
  logic drive_medium;
  assign internal_lb  = sel[LB_INTERNAL];
  assign drive_medium = sel[LB_NORMAL] | sel[LB_MEDIUM];

  always_comb begin
    endec_txd_o    = internal_lb ? '0 : ser_txd_i;
    medium_tx_en_o = drive_medium & tx_en_i;
    endec_loop_o   = sel[LB_ENDEC];
    deser_rxd_o    = internal_lb ? ser_txd_i : endec_rxd_i;
    deser_clk_o    = internal_lb ? tx_clk_i  : endec_rx_clk_i;
  end

  assign path_sel_o = sel;

  assert_path_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(path_sel_o) == 1);

  assert_internal_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_sel_o[1] |-> (!medium_tx_en_o && endec_txd_o == '0));

  assert_endec_no_medium_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    endec_loop_o |-> !medium_tx_en_o);

  assert_medium_follows_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    medium_tx_en_o |-> (tx_en_i && !endec_loop_o));
endmodule

// File: rtl/lb_rx_check.sv
module lb_rx_check
  import lb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lb_mode_e mode_i,
  input  logic     crc_en_i,
  input  logic     tx_start_i,
  input  logic     rx_eof_i,
  input  logic     rx_addr_hit_i,
  input  logic     rx_crc_ok_i,
  output logic     addr_match_o,
  output logic     crc_pass_o,
  output logic     crc_fail_o,
  output logic     lb_active_o
);
  logic eof_q, eof_rise, crc_check;
  logic addr_q, pass_q, fail_q, act_q;

  assign eof_rise  = rx_eof_i & ~eof_q;
  assign crc_check = (mode_i == LB_NORMAL) | crc_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eof_q  <= 1'b0;
      addr_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      eof_q  <= rx_eof_i;
      addr_q <= eof_rise & rx_addr_hit_i;
      pass_q <= eof_rise & crc_check & rx_crc_ok_i;
      fail_q <= eof_rise & crc_check & ~rx_crc_ok_i;
      if (tx_start_i && mode_i != LB_NORMAL)          act_q <= 1'b1;
      else if (eof_rise || mode_i == LB_NORMAL)       act_q <= 1'b0;
    end
  end

  assign addr_match_o = addr_q;
  assign crc_pass_o   = pass_q;
  assign crc_fail_o   = fail_q;
  assign lb_active_o  = act_q;

  assert_addr_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |=> !addr_match_o);

  assert_crc_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(crc_pass_o && crc_fail_o));

  assert_crc_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != LB_NORMAL && !crc_en_i) |=> !(crc_pass_o || crc_fail_o));

  assert_active_needs_lb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lb_active_o) |-> $past(tx_start_i));
endmodule

// File: rtl/loopback_ctrl.sv
module loopback_ctrl
  import lb_pkg::*;
#(
  parameter int SER_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             cfg_crc_en_i,
  input  logic             tx_start_i,
  input  logic             tx_en_i,
  input  logic [SER_W-1:0] ser_txd_i,
  input  logic             tx_clk_i,
  input  logic [SER_W-1:0] endec_rxd_i,
  input  logic             endec_rx_clk_i,
  input  logic             rx_eof_i,
  input  logic             rx_addr_hit_i,
  input  logic             rx_crc_ok_i,
  output logic [1:0]       mode_o,
  output logic [3:0]       path_sel_o,
  output logic             lb_illegal_o,
  output logic             tx_crc_gen_o,
  output logic             lb_active_o,
  output logic [SER_W-1:0] endec_txd_o,
  output logic             medium_tx_en_o,
  output logic             endec_loop_o,
  output logic [SER_W-1:0] deser_rxd_o,
  output logic             deser_clk_o,
  output logic             addr_match_o,
  output logic             crc_pass_o,
  output logic             crc_fail_o
);
  lb_mode_e mode;
  logic     crc_en;

  lb_mode_reg u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cfg_we_i),
    .wr_mode_i   (cfg_mode_i),
    .wr_crc_en_i (cfg_crc_en_i),
    .mode_o      (mode),
    .crc_en_o    (crc_en),
    .illegal_o   (lb_illegal_o)
  );

  lb_path_mux #(.SER_W(SER_W)) u_mux (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode),
    .tx_en_i        (tx_en_i),
    .ser_txd_i      (ser_txd_i),
    .tx_clk_i       (tx_clk_i),
    .endec_rxd_i    (endec_rxd_i),
    .endec_rx_clk_i (endec_rx_clk_i),
    .path_sel_o     (path_sel_o),
    .endec_txd_o    (endec_txd_o),
    .medium_tx_en_o (medium_tx_en_o),
    .endec_loop_o   (endec_loop_o),
    .deser_rxd_o    (deser_rxd_o),
    .deser_clk_o    (deser_clk_o)
  );

  lb_rx_check u_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode),
    .crc_en_i      (crc_en),
    .tx_start_i    (tx_start_i),
    .rx_eof_i      (rx_eof_i),
    .rx_addr_hit_i (rx_addr_hit_i),
    .rx_crc_ok_i   (rx_crc_ok_i),
    .addr_match_o  (addr_match_o),
    .crc_pass_o    (crc_pass_o),
    .crc_fail_o    (crc_fail_o),
    .lb_active_o   (lb_active_o)
  );

  assign mode_o       = mode;
  assign tx_crc_gen_o = crc_en;

  assert_crc_gen_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'b00) |=> (tx_crc_gen_o == $past(cfg_crc_en_i)));
endmodule

// File: tb/tb_loopback_ctrl.sv
module tb_loopback_ctrl;
  localparam int SER_W = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, we, crc_in, tx_start, tx_en, txd, txc, erxd, erxc, eof, hit, ok;
  logic [1:0] mode_in;
  logic [1:0] mode_o;
  logic [3:0] path_sel;
  logic ill, crc_gen, active, etxd, med_en, eloop, drxd, dclk, am, cp, cf;

  loopback_ctrl #(.SER_W(SER_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_mode_i(mode_in),
    .cfg_crc_en_i(crc_in), .tx_start_i(tx_start), .tx_en_i(tx_en),
    .ser_txd_i(txd), .tx_clk_i(txc), .endec_rxd_i(erxd), .endec_rx_clk_i(erxc),
    .rx_eof_i(eof), .rx_addr_hit_i(hit), .rx_crc_ok_i(ok),
    .mode_o(mode_o), .path_sel_o(path_sel), .lb_illegal_o(ill),
    .tx_crc_gen_o(crc_gen), .lb_active_o(active), .endec_txd_o(etxd),
    .medium_tx_en_o(med_en), .endec_loop_o(eloop), .deser_rxd_o(drxd),
    .deser_clk_o(dclk), .addr_match_o(am), .crc_pass_o(cp), .crc_fail_o(cf)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {we, mode[1:0], crc, exp_mode[1:0], exp_crc, exp_illegal}
  localparam logic [7:0] VEC [12] = '{
    8'b1_01_1_01_1_0,
    8'b1_10_0_01_1_1,
    8'b1_11_0_01_1_1,
    8'b1_01_0_01_0_1,
    8'b1_00_0_00_0_0,
    8'b1_10_1_10_1_0,
    8'b1_01_1_10_1_1,
    8'b1_00_1_00_1_0,
    8'b1_11_0_11_0_0,
    8'b1_10_1_11_0_1,
    8'b0_10_1_11_0_1,
    8'b1_00_0_00_0_0
  };

  task automatic wr(input logic [1:0] m, input logic c);
    @(negedge clk);
    we = 1'b1; mode_in = m; crc_in = c;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m, input logic c);
    wr(2'b00, c);
    wr(m, c);
  endtask

  task automatic route(input string req, input logic [1:0] m);
    for (int p = 0; p < 4; p++) begin
      txd = p[0]; erxd = ~p[0]; txc = p[1]; erxc = ~p[1]; tx_en = p[0] ^ p[1];
      #0.5;
      case (m)
        2'b01: begin
          chk(req, {drxd, dclk}, {txd, txc});
          chk(req, {etxd, med_en, eloop}, 3'b000);
        end
        2'b10: begin
          chk(req, {drxd, dclk}, {erxd, erxc});
          chk(req, {etxd, med_en, eloop}, {txd, 2'b01});
        end
        default: begin
          chk(req, {drxd, dclk}, {erxd, erxc});
          chk(req, {etxd, med_en, eloop}, {txd, tx_en, 1'b0});
        end
      endcase
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; we = 0; mode_in = 0; crc_in = 0; tx_start = 0; tx_en = 0;
    txd = 0; txc = 0; erxd = 0; erxc = 0; eof = 0; hit = 0; ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {mode_o, crc_gen, ill, active}, 5'b00000);
    chk("R1", {am, cp, cf}, 3'b000);
    chk("R2", {4'b0, path_sel}, 8'b0001);

    // R3 R4 R8 R2: configuration vectors
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      we = VEC[i][7]; mode_in = VEC[i][6:5]; crc_in = VEC[i][4];
      @(negedge clk);
      we = 1'b0;
      chk(VEC[i][0] ? "R4" : "R3", {6'b0, mode_o}, {6'b0, VEC[i][3:2]});
      chk("R8", {7'b0, crc_gen}, {7'b0, VEC[i][1]});
      chk("R4", {7'b0, ill}, {7'b0, VEC[i][0]});
      chk("R2", {4'b0, path_sel}, 8'(1 << VEC[i][3:2]));
    end

    // Routing per mode
    set_mode(2'b00, 0); route("R7", 2'b00);
    set_mode(2'b01, 0); route("R5", 2'b01);
    set_mode(2'b10, 0); route("R6", 2'b10);
    set_mode(2'b11, 0); route("R7", 2'b11);

    // R9 R10: normal mode always checks CRC; held eof gives one pulse
    set_mode(2'b00, 0);
    @(negedge clk); eof = 1; hit = 1; ok = 1;
    @(negedge clk);
    chk("R9", {5'b0, am, cp, cf}, 8'b110);
    @(negedge clk);
    chk("R9", {5'b0, am, cp, cf}, 8'b000);
    eof = 0;

    // R10: loopback without CRC enable -> no verdict
    set_mode(2'b01, 0);
    @(negedge clk); eof = 1; hit = 0; ok = 0;
    @(negedge clk); eof = 0;
    chk("R10", {5'b0, am, cp, cf}, 8'b000);

    // R10: loopback with CRC enable, bad CRC
    set_mode(2'b10, 1);
    @(negedge clk); eof = 1; hit = 1; ok = 0;
    @(negedge clk); eof = 0;
    chk("R10", {5'b0, am, cp, cf}, 8'b101);

    // R11: in-flight flag
    set_mode(2'b01, 1);
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
    chk("R11", {7'b0, active}, 8'd1);
    @(negedge clk); eof = 1;
    @(negedge clk); eof = 0;
    chk("R11", {7'b0, active}, 8'd0);
    set_mode(2'b00, 0);
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
    chk("R11", {7'b0, active}, 8'd0);

    // R1: asynchronous reset from a loopback state
    set_mode(2'b11, 1);
    wr(2'b01, 0);
    rst_n = 0; #1;
    chk("R1", {3'b0, mode_o, crc_gen, ill, active}, 8'd0);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule